// File: doc/BRIEF.md
# Page-Write Buffer and Word-Address Counter

This block sits behind a two-wire serial memory slave's bus engine. It keeps the word-address counter, gathers incoming data bytes into a page latch, and commits them to a behavioural byte array once the transaction closes. The bus engine reports five events as single-cycle strobes: transaction start, address load, data byte, read advance and STOP. The block answers with the byte at the current address, the counter value and a busy flag.

Writes stay inside one page, which is 2^PAGE_W bytes on a page boundary. A write may begin at any offset in the page, and the offset wraps within that page. Reads step through the whole array and wrap from the top address back to zero. Between transactions the counter holds the address after the last byte accessed.

A STOP that follows at least one latched byte starts a self-timed program window. The window lasts a parameterised number of clock cycles. During it the latched bytes are copied into the array one offset per cycle. The array defaults to 2K bytes so that it elaborates quickly; setting ADDR_W to 15 gives a 32K x 8 part.

Top module: `page_commit_unit`

## Requirements
- R1: After a synchronous reset, busy_o is 0 and cur_addr_o is 0.
- R2: An address-load strobe sets cur_addr_o to addr_i on the next cycle, and rd_data_o always shows the array byte at cur_addr_o.
- R3: An accepted data byte increments only the low PAGE_W address bits, wrapping from the last offset of the page to offset 0. The upper address bits do not change.
- R4: When more than 2^PAGE_W bytes arrive in one transaction, a later byte replaces the earlier byte at the same offset, and only the final value is committed.
- R5: A read-advance strobe increments the full address, wrapping from 2^ADDR_W-1 to 0.
- R6: A commit updates only the page offsets written since the last start strobe. All other locations keep their contents.
- R7: busy_o rises on the cycle after a STOP that has latched data behind it. It stays high for exactly max(WR_CYCLES, 2^PAGE_W) cycles.
- R8: While busy_o is high, the start, load, data, read-advance and STOP strobes have no effect on the counter or the array.
- R9: While wp_i is 1, a data byte is neither latched nor counted, and the following STOP starts no program window.
- R10: A STOP that has no latched data since the last start strobe leaves busy_o at 0.
- R11: After a committed write, cur_addr_o holds the address after the last written byte, wrapped within its page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_i | input | 1 | Write protect; 1 blocks data latching |
| start_i | input | 1 | Transaction start strobe; clears the page latch |
| addr_load_i | input | 1 | Loads addr_i into the counter |
| addr_i | input | ADDR_W | Word address to load |
| wr_byte_i | input | 1 | Data byte strobe |
| wr_data_i | input | DATA_W | Data byte value |
| rd_adv_i | input | 1 | Read advance strobe |
| stop_i | input | 1 | STOP strobe; commits latched data |
| rd_data_o | output | DATA_W | Array byte at the current address |
| cur_addr_o | output | ADDR_W | Current word-address counter |
| busy_o | output | 1 | Program window in progress |

## Verification
Two behaviours are hard to reach from the ports. The first is the in-page wrap with overwrite: an earlier byte in the latch must be replaced before the commit. The bench reaches it by starting a write two bytes before the end of a page and by sending one byte more than a full page. The second is the behaviour of strobes that arrive inside the program window. The bench sends them right after STOP, then reads back both the counter and the targeted locations once busy clears. Untouched neighbours are preloaded through single-byte transactions, so a commit that writes too many locations shows up in the read-back.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_LOAD,
        CNT_PAGE_INC,
        CNT_FULL_INC
    } cnt_op_e;

    typedef struct packed {
        logic start;
        logic load;
        logic wbyte;
        logic radv;
        logic stop;
    } bus_evt_t;

    function automatic int unsigned window_len(input int unsigned wr_cycles,
                                               input int unsigned page_bytes);
        return (wr_cycles < page_bytes) ? page_bytes : wr_cycles;
    endfunction

endpackage

// File: rtl/word_addr_counter.sv
module word_addr_counter
    import page_commit_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_op_e           op,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;
    logic [PAGE_W-1:0] offs_next;

    assign offs_next = addr_q[PAGE_W-1:0] + 1'b1;

    always_comb begin
        unique case (op)
            CNT_LOAD:     addr_d = load_val;
            CNT_PAGE_INC: addr_d = {addr_q[ADDR_W-1:PAGE_W], offs_next};
            CNT_FULL_INC: addr_d = addr_q + 1'b1;
            default:      addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/page_latch.sv
module page_latch #(
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8,
    localparam int PAGE_BYTES = 1 << PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_off,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rd_valid,
    output logic              any_valid
);
    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_off == PAGE_W'(s));

        always_ff @(posedge clk) begin
            if (hit) slot_q[s] <= wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst || clr) mask_q[s] <= 1'b0;
            else if (hit)   mask_q[s] <= 1'b1;
        end
    end

    assign rd_byte   = slot_q[rd_off];
    assign rd_valid  = mask_q[rd_off];
    assign any_valid = |mask_q;
endmodule

// File: rtl/commit_sequencer.sv
module commit_sequencer #(
    parameter int PAGE_W   = 6,
    parameter int WIN_LEN  = 64,
    localparam int PAGE_BYTES = 1 << PAGE_W,
    localparam int TW         = $clog2(WIN_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    output logic            busy,
    output logic            step,
    output logic [PAGE_W:0] idx,
    output logic            done
);
    localparam logic [TW-1:0] TMR_INIT = TW'(WIN_LEN - 1);

    logic            busy_q;
    logic [TW-1:0]   tmr_q;
    logic [PAGE_W:0] idx_q;

    assign step = busy_q && (idx_q < (PAGE_W+1)'(PAGE_BYTES));
    assign done = busy_q && (tmr_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            tmr_q  <= '0;
            idx_q  <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            tmr_q  <= TMR_INIT;
            idx_q  <= '0;
        end else if (busy_q) begin
            if (step) idx_q <= idx_q + 1'b1;
            if (tmr_q == '0) busy_q <= 1'b0;
            else             tmr_q  <= tmr_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign idx  = idx_q;
endmodule

// File: rtl/byte_array.sv
module byte_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit
    import page_commit_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 6,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 600000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_i,
    input  logic              start_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_byte_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_adv_i,
    input  logic              stop_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              busy_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int TMR_LOAD   = int'(window_len(WR_CYCLES, PAGE_BYTES));
    localparam int HI_W       = ADDR_W - PAGE_W;

    bus_evt_t          evt;
    cnt_op_e           cnt_op;
    logic              busy;
    logic              step;
    logic              done;
    logic [PAGE_W:0]   idx;
    logic              latch_wr;
    logic              latch_clr;
    logic              go;
    logic              any_valid;
    logic              slot_valid;
    logic [DATA_W-1:0] slot_byte;
    logic [HI_W-1:0]   base_q;
    logic [ADDR_W-1:0] addr;

    // Strobes are only honoured outside the program window.
    always_comb begin
        evt.start = start_i     && !busy;
        evt.load  = addr_load_i && !busy;
        evt.wbyte = wr_byte_i   && !busy;
        evt.radv  = rd_adv_i    && !busy;
        evt.stop  = stop_i      && !busy;
    end

    always_comb begin
        if (evt.load)                cnt_op = CNT_LOAD;
        else if (evt.wbyte && !wp_i) cnt_op = CNT_PAGE_INC;
        else if (evt.radv)           cnt_op = CNT_FULL_INC;
        else                         cnt_op = CNT_HOLD;
    end

    assign latch_wr  = evt.wbyte && !evt.load && !wp_i;
    assign latch_clr = evt.start || done;
    assign go        = evt.stop && !evt.start && any_valid;

    word_addr_counter #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .op       (cnt_op),
        .load_val (addr_i),
        .addr     (addr)
    );

    page_latch #(
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) latch_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (latch_clr),
        .wr_en     (latch_wr),
        .wr_off    (addr[PAGE_W-1:0]),
        .wr_data   (wr_data_i),
        .rd_off    (idx[PAGE_W-1:0]),
        .rd_byte   (slot_byte),
        .rd_valid  (slot_valid),
        .any_valid (any_valid)
    );

    commit_sequencer #(
        .PAGE_W  (PAGE_W),
        .WIN_LEN (TMR_LOAD)
    ) seq_i (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .busy (busy),
        .step (step),
        .idx  (idx),
        .done (done)
    );

    always_ff @(posedge clk) begin
        if (rst)     base_q <= '0;
        else if (go) base_q <= addr[ADDR_W-1:PAGE_W];
    end

    byte_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) mem_i (
        .clk   (clk),
        .we    (step && slot_valid),
        .waddr ({base_q, idx[PAGE_W-1:0]}),
        .wdata (slot_byte),
        .raddr (addr),
        .rdata (rd_data_o)
    );

    assign cur_addr_o = addr;
    assign busy_o     = busy;
endmodule

// File: rtl/page_commit_unit_chk.sv
module page_commit_unit_chk #(
    parameter int ADDR_W   = 11,
    parameter int PAGE_W   = 6,
    parameter int TMR_LOAD = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              wp_i,
    input logic              addr_load_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_byte_i,
    input logic              rd_adv_i,
    input logic              stop_i,
    input logic [ADDR_W-1:0] cur_addr_o,
    input logic              busy_o,
    input logic              any_valid
);
    int unsigned blen;

    always_ff @(posedge clk) begin
        if (rst)         blen <= 0;
        else if (busy_o) blen <= blen + 1;
        else             blen <= 0;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(addr_load_i && !busy_o)) |-> cur_addr_o == $past(addr_i));

    assert_page_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_byte_i && !addr_load_i && !busy_o && !wp_i)) |->
        (cur_addr_o[ADDR_W-1:PAGE_W] == $past(cur_addr_o[ADDR_W-1:PAGE_W]) &&
         cur_addr_o[PAGE_W-1:0] == PAGE_W'($past(cur_addr_o[PAGE_W-1:0]) + 1'b1)));

    assert_full_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_adv_i && !wr_byte_i && !addr_load_i && !busy_o)) |->
        cur_addr_o == ADDR_W'($past(cur_addr_o) + 1'b1));

    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_i));

    assert_busy_len_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> blen == TMR_LOAD);

    assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(busy_o)) |-> $stable(cur_addr_o));

    assert_wp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wp_i && wr_byte_i && !addr_load_i && !rd_adv_i && !busy_o)) |->
        $stable(cur_addr_o));

    assert_empty_stop_R10: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !busy_o && !any_valid) |=> !busy_o);
endmodule

bind page_commit_unit page_commit_unit_chk #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W),
    .TMR_LOAD (TMR_LOAD)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .wp_i        (wp_i),
    .addr_load_i (addr_load_i),
    .addr_i      (addr_i),
    .wr_byte_i   (wr_byte_i),
    .rd_adv_i    (rd_adv_i),
    .stop_i      (stop_i),
    .cur_addr_o  (cur_addr_o),
    .busy_o      (busy_o),
    .any_valid   (any_valid)
);

// File: tb/page_commit_unit_tb_top.sv
module page_commit_unit_tb_top;
    localparam int AW = 11;
    localparam int PW = 6;
    localparam int DW = 8;
    localparam int WC = 80;
    localparam int NV = 8;

    localparam logic [AW+DW-1:0] VEC [NV] = '{
        {11'h041, 8'h5A}, {11'h200, 8'h3C}, {11'h000, 8'h11}, {11'h7FF, 8'hEE},
        {11'h13F, 8'h77}, {11'h300, 8'h99}, {11'h0C0, 8'h42}, {11'h555, 8'hA5}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wp_i = 1'b0;
    logic          start_i = 1'b0;
    logic          addr_load_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          wr_byte_i = 1'b0;
    logic [DW-1:0] wr_data_i = '0;
    logic          rd_adv_i = 1'b0;
    logic          stop_i = 1'b0;
    logic [DW-1:0] rd_data_o;
    logic [AW-1:0] cur_addr_o;
    logic          busy_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    page_commit_unit #(
        .ADDR_W (AW), .PAGE_W (PW), .DATA_W (DW), .WR_CYCLES (WC)
    ) dut_i (
        .clk (clk), .rst (rst), .wp_i (wp_i), .start_i (start_i),
        .addr_load_i (addr_load_i), .addr_i (addr_i), .wr_byte_i (wr_byte_i),
        .wr_data_i (wr_data_i), .rd_adv_i (rd_adv_i), .stop_i (stop_i),
        .rd_data_o (rd_data_o), .cur_addr_o (cur_addr_o), .busy_o (busy_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ev_start;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask
    task automatic ev_load(input logic [AW-1:0] a);
        @(negedge clk) begin addr_load_i = 1'b1; addr_i = a; end
        @(negedge clk) addr_load_i = 1'b0;
    endtask
    task automatic ev_byte(input logic [DW-1:0] d);
        @(negedge clk) begin wr_byte_i = 1'b1; wr_data_i = d; end
        @(negedge clk) wr_byte_i = 1'b0;
    endtask
    task automatic ev_radv;
        @(negedge clk) rd_adv_i = 1'b1;
        @(negedge clk) rd_adv_i = 1'b0;
    endtask
    task automatic ev_stop;
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask
    task automatic wait_idle;
        while (busy_o) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", {31'd0, busy_o}, 32'd0);
        check("R1 addr", {21'd0, cur_addr_o}, 32'd0);

        // Table walk: single-byte transactions and their read-back.
        for (int v = 0; v < NV; v++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic [AW-1:0] nxt;
            a   = VEC[v][AW+DW-1:DW];
            d   = VEC[v][DW-1:0];
            nxt = {a[AW-1:PW], PW'(a[PW-1:0] + 1'b1)};
            ev_start();
            ev_load(a);
            check("R2 load", {21'd0, cur_addr_o}, {21'd0, a});
            ev_byte(d);
            ev_stop();
            wait_idle();
            check("R11 next", {21'd0, cur_addr_o}, {21'd0, nxt});
            ev_load(a);
            check("R6 data", {24'd0, rd_data_o}, {24'd0, d});
        end

        // R3/R7: in-page wrap and window length.
        ev_start();
        ev_load(11'h07E);
        ev_byte(8'hA1);
        ev_byte(8'hB2);
        ev_byte(8'hC3);
        check("R3 wrap", {21'd0, cur_addr_o}, 32'h041);
        ev_stop();
        check("R7 rise", {31'd0, busy_o}, 32'd1);
        repeat (WC - 1) @(negedge clk);
        check("R7 last", {31'd0, busy_o}, 32'd1);
        @(negedge clk);
        check("R7 end", {31'd0, busy_o}, 32'd0);
        ev_load(11'h040);
        check("R3 off0", {24'd0, rd_data_o}, 32'hC3);
        ev_load(11'h07F);
        check("R3 off63", {24'd0, rd_data_o}, 32'hB2);
        ev_load(11'h07E);
        check("R3 off62", {24'd0, rd_data_o}, 32'hA1);
        ev_load(11'h041);
        check("R6 untouched", {24'd0, rd_data_o}, 32'h5A);

        // R4: one byte beyond a full page.
        ev_start();
        ev_load(11'h100);
        for (int i = 0; i <= 64; i++) ev_byte(8'(i));
        check("R4 addr", {21'd0, cur_addr_o}, 32'h101);
        ev_stop();
        wait_idle();
        ev_load(11'h100);
        check("R4 replaced", {24'd0, rd_data_o}, 32'h40);
        ev_load(11'h101);
        check("R4 kept1", {24'd0, rd_data_o}, 32'h01);
        ev_load(11'h13F);
        check("R4 kept63", {24'd0, rd_data_o}, 32'h3F);

        // R8: strobes inside the program window.
        ev_start();
        ev_load(11'h400);
        ev_byte(8'h77);
        ev_stop();
        ev_start();
        ev_load(11'h300);
        ev_byte(8'hFF);
        ev_radv();
        ev_stop();
        check("R8 addr", {21'd0, cur_addr_o}, 32'h401);
        wait_idle();
        check("R8 busy", {31'd0, busy_o}, 32'd0);
        ev_load(11'h300);
        check("R8 data", {24'd0, rd_data_o}, 32'h99);
        ev_load(11'h400);
        check("R8 own", {24'd0, rd_data_o}, 32'h77);

        // R9: write protect.
        ev_start();
        wp_i = 1'b1;
        ev_load(11'h200);
        ev_byte(8'hFF);
        check("R9 addr", {21'd0, cur_addr_o}, 32'h200);
        ev_stop();
        check("R9 busy", {31'd0, busy_o}, 32'd0);
        wp_i = 1'b0;
        ev_load(11'h200);
        check("R9 data", {24'd0, rd_data_o}, 32'h3C);

        // R10: STOP after address phase only.
        ev_start();
        ev_load(11'h555);
        ev_stop();
        check("R10 busy", {31'd0, busy_o}, 32'd0);
        check("R10 data", {24'd0, rd_data_o}, 32'hA5);

        // R5: read advance across page and array end.
        ev_load(11'h7FF);
        ev_radv();
        check("R5 top wrap", {21'd0, cur_addr_o}, 32'h000);
        check("R5 data", {24'd0, rd_data_o}, 32'h11);
        ev_load(11'h07F);
        ev_radv();
        check("R5 cross", {21'd0, cur_addr_o}, 32'h080);

        finish_run();
    end
endmodule